// File: doc/BRIEF.md
# Two-Level Propagate/Generate Adder

This block adds two 32-bit unsigned operands and a carry input in one purely combinational path. It returns a 32-bit sum and a carry output. Software-visible state, registers and handshakes are absent. The result follows the inputs directly.

Internally the word is cut into 4-bit slices. Each slice forms its own bit carries by lookahead. It also reports a group propagate and a group generate. Four slices make a 16-bit section. A section-level lookahead unit turns the slice group signals and the section carry-in into the carry for each slice and into a section carry-out. The lower section's carry-out feeds the upper section's carry-in, and the upper section's carry-out becomes the adder's carry output. The least significant slice takes the adder carry input unchanged.

Top module: `pg_adder32`

## Requirements
- R1: For every input combination, `{cout, sum}` equals the 33-bit arithmetic value `a + b + cin`.
- R2: When every bit position propagates (`a ^ b` is all ones), the carry input travels the full width: `sum` is all ones and `cout` is 0 when `cin` is 0, and `sum` is zero and `cout` is 1 when `cin` is 1.
- R3: When no bit position generates (`a & b` is zero) and `cin` is 0, `sum` equals `a | b` and `cout` is 0.
- R4: A carry leaving bit 15 reaches bit 16. For example, `32'h0000FFFF + 32'h00000001` gives `32'h00010000`, and the carry out of the lower 16 bits always equals bit 16 of `a[15:0] + b[15:0] + cin`.
- R5: `cout` carries the overflow out of bit 31. For example, `32'hFFFFFFFF + 32'h00000001` gives `sum` zero with `cout` 1, and `32'hFFFFFFFF + 32'hFFFFFFFF + 1` gives `sum` `32'hFFFFFFFF` with `cout` 1.
- R6: A carry generated in the top bit of any 4-bit slice (bit 4k+3, k from 0 to 6) enters the next slice: adding `1<<(4k+3)` to itself gives `1<<(4k+4)` with `cout` 0.
- R7: The carry input enters bit 0 directly: with `a` and `b` both zero, `sum` equals `cin` and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the total |
| cout | output | 1 | Carry out of bit 31 |

## Verification
Every result of this block depends only on the current inputs. `sum` and `cout` are therefore due in the same cycle in which the operands change, with no register in between. The bench applies each operand set just after a rising clock edge and reads the outputs at the following falling edge. By then the inputs have been stable for half a period, and no result depends on the order of processes at an edge. The section carry between the two halves is also compared, against the low-half total, whenever the operands change.

// File: rtl/pg_adder_pkg.sv
package pg_adder_pkg;

  // default geometry of the adder
  localparam int DEF_WIDTH   = 32;
  localparam int DEF_SLICE_W = 4;
  localparam int DEF_SLICES  = 4;

  // group signals reported by one slice
  typedef struct packed {
    logic grpProp;
    logic grpGen;
  } pgPair_t;

endpackage

// File: rtl/pg_lookahead.sv
// Flattened carry lookahead over N propagate/generate pairs.
// Used both inside a slice (bit level) and across slices (group level).
module pg_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cIn,
  output logic [N-1:0] carry,
  output logic         grpProp,
  output logic         grpGen
);

  logic [N-1:0] carryV;
  logic         genV;

  // carry k = OR over j<k of (gen[j] & prop[j+1..k-1]) | (prop[0..k-1] & cIn)
  always_comb begin
    logic acc;
    logic term;
    carryV = '0;
    for (int k = 0; k < N; k++) begin
      term = cIn;
      for (int m = 0; m < k; m++) term = term & prop[m];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = gen[j];
        for (int m = j + 1; m < k; m++) term = term & prop[m];
        acc = acc | term;
      end
      carryV[k] = acc;
    end
  end

  // group generate: same form, whole width, no carry-in term
  always_comb begin
    logic term;
    genV = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen[j];
      for (int m = j + 1; m < N; m++) term = term & prop[m];
      genV = genV | term;
    end
  end

  assign carry   = carryV;
  assign grpProp = &prop;
  assign grpGen  = genV;

endmodule

// File: rtl/pg_slice.sv
// One narrow adder slice with internal lookahead and group P/G outputs.
module pg_slice
  import pg_adder_pkg::*;
#(
  parameter int SLICE_W = DEF_SLICE_W
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cIn,
  output logic [SLICE_W-1:0] sum,
  output pgPair_t            grp
);

  logic [SLICE_W-1:0] bitProp;
  logic [SLICE_W-1:0] bitGen;
  logic [SLICE_W-1:0] bitCarry;
  logic               pOut;
  logic               gOut;

  assign bitProp = a ^ b;
  assign bitGen  = a & b;

  pg_lookahead #(.N(SLICE_W)) bitLa_i (
    .gen     (bitGen),
    .prop    (bitProp),
    .cIn     (cIn),
    .carry   (bitCarry),
    .grpProp (pOut),
    .grpGen  (gOut)
  );

  assign sum         = bitProp ^ bitCarry;
  assign grp.grpProp = pOut;
  assign grp.grpGen  = gOut;

endmodule

// File: rtl/pg_section.sv
// A section: SLICES slices tied together by one group lookahead unit.
module pg_section
  import pg_adder_pkg::*;
#(
  parameter int SLICE_W = DEF_SLICE_W,
  parameter int SLICES  = DEF_SLICES
) (
  input  logic [SLICE_W*SLICES-1:0] a,
  input  logic [SLICE_W*SLICES-1:0] b,
  input  logic                      cIn,
  output logic [SLICE_W*SLICES-1:0] sum,
  output logic                      cOut
);

  logic [SLICES-1:0] sliceProp;
  logic [SLICES-1:0] sliceGen;
  logic [SLICES-1:0] sliceCarry;
  logic              secProp;
  logic              secGen;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    pgPair_t grpK;
    pg_slice #(.SLICE_W(SLICE_W)) slice_i (
      .a   (a[k*SLICE_W +: SLICE_W]),
      .b   (b[k*SLICE_W +: SLICE_W]),
      .cIn (sliceCarry[k]),
      .sum (sum[k*SLICE_W +: SLICE_W]),
      .grp (grpK)
    );
    assign sliceProp[k] = grpK.grpProp;
    assign sliceGen[k]  = grpK.grpGen;
  end

  // slice 0 receives cIn itself (carry[0] of the unit is cIn)
  pg_lookahead #(.N(SLICES)) grpLa_i (
    .gen     (sliceGen),
    .prop    (sliceProp),
    .cIn     (cIn),
    .carry   (sliceCarry),
    .grpProp (secProp),
    .grpGen  (secGen)
  );

  assign cOut = secGen | (secProp & cIn);

endmodule

// File: rtl/pg_adder32.sv
// Top: sections chained end to end, carry rippling between them.
module pg_adder32
  import pg_adder_pkg::*;
#(
  parameter int WIDTH   = DEF_WIDTH,
  parameter int SLICE_W = DEF_SLICE_W,
  parameter int SLICES  = DEF_SLICES
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int SEC_W   = SLICE_W * SLICES;
  localparam int NUM_SEC = WIDTH / SEC_W;

  logic [NUM_SEC:0] secCarry;

  assign secCarry[0] = cin;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    pg_section #(.SLICE_W(SLICE_W), .SLICES(SLICES)) sec_i (
      .a    (a[s*SEC_W +: SEC_W]),
      .b    (b[s*SEC_W +: SEC_W]),
      .cIn  (secCarry[s]),
      .sum  (sum[s*SEC_W +: SEC_W]),
      .cOut (secCarry[s+1])
    );
  end

  assign cout = secCarry[NUM_SEC];

endmodule

// File: rtl/pg_adder32_chk.sv
// Checker bound into the adder top.
module pg_adder32_chk #(
  parameter int WIDTH   = 32,
  parameter int SEC_W   = 16,
  parameter int NUM_SEC = 2
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NUM_SEC:0] secCarry
);

  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    p_sum_exact_r1: assert ({cout, sum} == refTotal)
      else $error("R1 total mismatch");
    if ((a ^ b) == {WIDTH{1'b1}}) begin
      p_full_prop_r2: assert (sum == {WIDTH{~cin}} && cout == cin)
        else $error("R2 propagate chain broken");
    end
    if ((a & b) == '0 && !cin) begin
      p_no_gen_r3: assert (sum == (a | b) && !cout)
        else $error("R3 spurious carry");
    end
  end

  // carry between sections matches the lower part's arithmetic carry
  for (genvar s = 1; s < NUM_SEC; s++) begin : g_bound
    logic [s*SEC_W:0] lowTotal;
    assign lowTotal = {1'b0, a[s*SEC_W-1:0]} + {1'b0, b[s*SEC_W-1:0]}
                    + {{(s*SEC_W){1'b0}}, cin};
    always_comb begin
      p_section_carry_r4: assert (secCarry[s] == lowTotal[s*SEC_W])
        else $error("R4 section carry mismatch");
    end
  end

endmodule

bind pg_adder32 pg_adder32_chk #(
  .WIDTH(WIDTH), .SEC_W(SEC_W), .NUM_SEC(NUM_SEC)
) chk_i (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .secCarry(secCarry)
);

// File: tb/pg_adder32_tb_top.sv
module pg_adder32_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] aIn = '0;
  logic [31:0] bIn = '0;
  logic        cIn = 1'b0;
  logic [31:0] sumOut;
  logic        coutOut;
  int          checkCnt = 0;
  int          failCnt  = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pg_adder32 dut_i (
    .a(aIn), .b(bIn), .cin(cIn), .sum(sumOut), .cout(coutOut)
  );

  task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic cv);
    @(posedge clk);
    aIn <= av;
    bIn <= bv;
    cIn <= cv;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [32:0] expV);
    checkCnt++;
    if ({coutOut, sumOut} !== expV) begin
      failCnt++;
      $display("FAIL %s a=%h b=%h cin=%0d actual cout=%0d sum=%h expected cout=%0d sum=%h",
               tag, aIn, bIn, cIn, coutOut, sumOut, expV[32], expV[31:0]);
    end
  endtask

  function automatic logic [32:0] addRef(input logic [31:0] av, input logic [31:0] bv, input logic cv);
    return {1'b0, av} + {1'b0, bv} + {32'd0, cv};
  endfunction

  task automatic runAdd(input string tag, input logic [31:0] av, input logic [31:0] bv, input logic cv);
    apply(av, bv, cv);
    check(tag, addRef(av, bv, cv));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN <= 1'b1;
    @(negedge clk);

    // idle state: all-zero inputs give zero (R7 baseline)
    check("R7 idle", 33'd0);

    // R7: carry input alone
    apply(32'd0, 32'd0, 1'b1);
    check("R7", 33'd1);

    // R1: near-exhaustive sweep of byte-replicated operands
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y += 5) begin
        for (int c = 0; c < 2; c++) begin
          runAdd("R1 sweep", {4{x[7:0]}}, {4{y[7:0]}}, c[0]);
        end
      end
    end

    // R1: scattered operands
    for (int i = 0; i < 3000; i++) begin
      runAdd("R1 random", $urandom, $urandom, i[0]);
    end

    // R2: every bit propagates
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r, ~r, i[0]);
      check("R2", i[0] ? {1'b1, 32'd0} : {1'b0, 32'hFFFFFFFF});
    end

    // R3: no bit generates, cin low
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      logic [31:0] q;
      r = $urandom;
      q = ~r & $urandom;
      apply(r, q, 1'b0);
      check("R3", {1'b0, r | q});
    end

    // R4: carries across the section boundary
    apply(32'h0000FFFF, 32'h00000001, 1'b0);
    check("R4", {1'b0, 32'h00010000});
    apply(32'h00007FFF, 32'h00008000, 1'b1);
    check("R4", {1'b0, 32'h00010000});
    apply(32'h0000FFFF, 32'h00000000, 1'b1);
    check("R4", {1'b0, 32'h00010000});
    apply(32'h1234FFFF, 32'h00000001, 1'b0);
    check("R4", {1'b0, 32'h12350000});
    apply(32'h0000F000, 32'h00001000, 1'b0);
    check("R4", {1'b0, 32'h00010000});

    // R5: overflow out of bit 31
    apply(32'hFFFFFFFF, 32'h00000001, 1'b0);
    check("R5", {1'b1, 32'h00000000});
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    check("R5", {1'b1, 32'hFFFFFFFF});
    apply(32'h80000000, 32'h80000000, 1'b0);
    check("R5", {1'b1, 32'h00000000});
    apply(32'hFFFFFFFF, 32'h00000000, 1'b1);
    check("R5", {1'b1, 32'h00000000});

    // R6: carry generated at the top of each slice reaches the next slice
    for (int k = 0; k < 7; k++) begin
      logic [31:0] v;
      v = 32'd1 << (4 * k + 3);
      apply(v, v, 1'b0);
      check("R6", {1'b0, 32'd1 << (4 * k + 4)});
    end

    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

endmodule